// File: doc/BRIEF.md
# Normalizing Barrel Shifter

This unit is the shift stage of a 16-bit fixed-point datapath. Each issued operation places a 16-bit operand into the upper or lower half of a 32-bit field, shifts that field by a signed count and writes the outcome into a 32-bit result register one clock later. Besides plain logical and arithmetic shifts it can count the redundant sign bits of a word (exponent derivation), normalize a word so that its two top result bits differ, and denormalize by a right-shift count. The result can be ORed into what the register already holds, so values wider than 16 bits can be assembled over two operations.

For block floating-point, a block-exponent register keeps the smallest exponent derived since it was last cleared. Software streams a block of words through exponent derivation and reads back the common exponent. A normalize on the upper half also latches that word's exponent, and a normalize on the lower half then reuses it, so a two-word value is normalized as one.

Top module: `shiftUnit`

## Requirements
- R1: After a synchronous reset (rstN low at a clock edge), result, expOut and blockExp are all zero.
- R2: An operation is sampled on the rising edge where opValid is high and its outcome appears on the outputs right after that edge; with opValid low, result and expOut keep their values.
- R3: Placement: with hiSel=1 the operand occupies result bits 31:16 and bits 15:0 start at zero; with hiSel=0 it occupies bits 15:0 and bits 31:16 start at zero (no sign extension), before shifting.
- R4: opCode 0 (logical shift): a positive shiftAmt shifts left, a negative one shifts right with zero fill; a magnitude of 32 or more gives zero.
- R5: opCode 1 (arithmetic shift): as R4, but right shifts fill with a copy of bit 31 of the placed value, and a right magnitude of 32 or more gives all copies of that bit.
- R6: opCode 4 (derive exponent): expOut becomes minus the number of bits below bit 15 of dataIn that equal bit 15 (0x0000 and 0xFFFF give -15, 0x4000 gives 0); result is left unchanged.
- R7: opCode 2 with hiSel=1 (normalize upper): the exponent of dataIn is derived as in R6, latched into expOut, and the placed value is shifted left by its negation, so for a nonzero operand bit 31 differs from bit 30.
- R8: opCode 2 with hiSel=0 (normalize lower): the placed value is shifted left by the negation of the exponent already held in expOut, and expOut is unchanged.
- R9: opCode 3 (denormalize): shiftAmt is a right-shift count with arithmetic fill; a negative shiftAmt shifts left.
- R10: With orMode=1 on opCodes 0 to 3, the new result is the shifted value ORed with the previous result.
- R11: On every opCode 4, blockExp becomes the minimum of itself and the derived exponent; expClr alone sets blockExp to 0, and expClr together with opCode 4 sets it to that operation's exponent.
- R12: opCodes 5, 6 and 7 change none of result, expOut and blockExp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| opValid | input | 1 | Issue strobe for the operation on the other inputs |
| opCode | input | 3 | 0 logical, 1 arithmetic, 2 normalize, 3 denormalize, 4 derive exponent |
| hiSel | input | 1 | Place operand in upper (1) or lower (0) half |
| orMode | input | 1 | OR the shifted value into the previous result |
| shiftAmt | input | 8 | Signed shift count |
| dataIn | input | 16 | Operand word |
| expClr | input | 1 | Synchronous clear of the block exponent |
| result | output | 32 | Registered shift result |
| expOut | output | 8 | Last derived exponent, signed |
| blockExp | output | 8 | Running minimum exponent, signed |

## Verification
The bench drives shift counts at and beyond the 32-bit edge in both directions and at -128, where a design that saturated wrongly would wrap the count and return a shifted copy instead of zero or a full sign word. Lower-half arithmetic shifts catch a design that sign-extends the low word, and the all-zero and all-one words catch an exponent counter that stops at 14 or counts bit 15 itself. A two-word normalize with OR checks that the lower half reuses the held exponent rather than deriving its own, and clears issued with and without a concurrent derive catch a block register that drops the current word or keeps a stale minimum.

// File: rtl/shiftPkg.sv
package shiftPkg;

  typedef enum logic [2:0] {
    OP_LSH    = 3'd0,
    OP_ASH    = 3'd1,
    OP_NORM   = 3'd2,
    OP_DENORM = 3'd3,
    OP_EXP    = 3'd4
  } shOp_e;

  typedef enum logic [1:0] {
    AMT_DIRECT = 2'd0,
    AMT_INVERT = 2'd1,
    AMT_NEWEXP = 2'd2,
    AMT_OLDEXP = 2'd3
  } amtSel_e;

  typedef struct packed {
    logic    ldResult;
    logic    ldExp;
    logic    ldBlock;
    logic    orIn;
    logic    arith;
    logic    hiPlace;
    amtSel_e amtSel;
  } shStrobe_t;

endpackage

// File: rtl/shiftCtrl.sv
module shiftCtrl
  import shiftPkg::*;
(
  input  logic      opValid,
  input  logic [2:0] opCode,
  input  logic      hiSel,
  input  logic      orMode,
  output shStrobe_t strobe
);

  always_comb begin
    strobe          = '0;
    strobe.orIn     = orMode;
    strobe.hiPlace  = hiSel;
    strobe.amtSel   = AMT_DIRECT;
    if (opValid) begin
      case (opCode)
        OP_LSH: begin
          strobe.ldResult = 1'b1;
        end
        OP_ASH: begin
          strobe.ldResult = 1'b1;
          strobe.arith    = 1'b1;
        end
        OP_NORM: begin
          strobe.ldResult = 1'b1;
          strobe.arith    = 1'b1;
          strobe.ldExp    = hiSel;
          strobe.amtSel   = hiSel ? AMT_NEWEXP : AMT_OLDEXP;
        end
        OP_DENORM: begin
          strobe.ldResult = 1'b1;
          strobe.arith    = 1'b1;
          strobe.amtSel   = AMT_INVERT;
        end
        OP_EXP: begin
          strobe.ldExp    = 1'b1;
          strobe.ldBlock  = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/shiftPath.sv
module shiftPath
  import shiftPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  shStrobe_t                strobe,
  input  logic [AMT_W-1:0]         shiftAmt,
  input  logic [DATA_W-1:0]        dataIn,
  input  logic                     expClr,
  output logic [2*DATA_W-1:0]      resultQ,
  output logic signed [AMT_W-1:0]  expQ,
  output logic signed [AMT_W-1:0]  blockQ
);

  localparam int RES_W = 2 * DATA_W;
  localparam int SA_W  = AMT_W + 1;

  logic [AMT_W-1:0]        signCnt;
  logic signed [AMT_W-1:0] newExp;
  logic signed [SA_W-1:0]  effAmt;
  logic [RES_W-1:0]        placed;
  logic [RES_W-1:0]        shifted;

  // redundant sign bit count below the top bit
  always_comb begin
    logic run;
    run     = 1'b1;
    signCnt = '0;
    for (int i = DATA_W - 2; i >= 0; i--) begin
      if (run && (dataIn[i] == dataIn[DATA_W-1])) signCnt = signCnt + 1'b1;
      else run = 1'b0;
    end
    newExp = $signed(AMT_W'(0) - signCnt);
  end

  always_comb begin
    case (strobe.amtSel)
      AMT_DIRECT: effAmt = $signed({shiftAmt[AMT_W-1], shiftAmt});
      AMT_INVERT: effAmt = -$signed({shiftAmt[AMT_W-1], shiftAmt});
      AMT_NEWEXP: effAmt = -$signed({newExp[AMT_W-1], newExp});
      default:    effAmt = -$signed({expQ[AMT_W-1], expQ});
    endcase
  end

  assign placed = strobe.hiPlace ? {dataIn, {DATA_W{1'b0}}} : {{DATA_W{1'b0}}, dataIn};

  function automatic logic [RES_W-1:0] barrel(input logic [RES_W-1:0] v,
                                               input logic signed [SA_W-1:0] a,
                                               input logic ar);
    logic [SA_W-1:0] mag;
    logic            big;
    mag = a[SA_W-1] ? SA_W'(-a) : SA_W'(a);
    big = (mag >= SA_W'(RES_W));
    if (!a[SA_W-1])  return big ? '0 : (v << mag);
    else if (ar)     return big ? {RES_W{v[RES_W-1]}} : RES_W'($signed(v) >>> mag);
    else             return big ? '0 : (v >> mag);
  endfunction

  assign shifted = barrel(placed, effAmt, strobe.arith);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      expQ    <= '0;
      blockQ  <= '0;
    end else begin
      if (strobe.ldResult) resultQ <= strobe.orIn ? (resultQ | shifted) : shifted;
      if (strobe.ldExp)    expQ    <= newExp;
      if (strobe.ldBlock)  blockQ  <= (expClr || (newExp < blockQ)) ? newExp : blockQ;
      else if (expClr)     blockQ  <= '0;
    end
  end

  p_hold_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldResult |=> $stable(resultQ));

  p_exp_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (expQ <= 0) && (expQ >= -(DATA_W - 1)));

  p_norm_msb_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldResult && strobe.amtSel == AMT_NEWEXP && !strobe.orIn && dataIn != '0)
    |=> (resultQ[RES_W-1] != resultQ[RES_W-2]));

  p_exp_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldExp |=> $stable(expQ));

  p_block_min_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldBlock && !expClr) |=> (blockQ <= $past(blockQ)) && (blockQ <= expQ));

  p_block_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (expClr && !strobe.ldBlock) |=> (blockQ == 0));

endmodule

// File: rtl/shiftUnit.sv
module shiftUnit
  import shiftPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opValid,
  input  logic [2:0]            opCode,
  input  logic                  hiSel,
  input  logic                  orMode,
  input  logic [AMT_W-1:0]      shiftAmt,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic                  expClr,
  output logic [2*DATA_W-1:0]   result,
  output logic [AMT_W-1:0]      expOut,
  output logic [AMT_W-1:0]      blockExp
);

  shStrobe_t               strobe;
  logic signed [AMT_W-1:0] expQ;
  logic signed [AMT_W-1:0] blockQ;

  shiftCtrl uCtrl (
    .opValid (opValid),
    .opCode  (opCode),
    .hiSel   (hiSel),
    .orMode  (orMode),
    .strobe  (strobe)
  );

  shiftPath #(.DATA_W(DATA_W), .AMT_W(AMT_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .shiftAmt (shiftAmt),
    .dataIn   (dataIn),
    .expClr   (expClr),
    .resultQ  (result),
    .expQ     (expQ),
    .blockQ   (blockQ)
  );

  assign expOut   = expQ;
  assign blockExp = blockQ;

endmodule

// File: tb/sim_shiftUnit.sv
`timescale 1ns/1ps
module sim_shiftUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic        hiSel = 1'b0;
  logic        orMode = 1'b0;
  logic [7:0]  shiftAmt = '0;
  logic [15:0] dataIn = '0;
  logic        expClr = 1'b0;
  logic [31:0] result;
  logic [7:0]  expOut;
  logic [7:0]  blockExp;

  always #2 clk = ~clk;

  shiftUnit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .hiSel(hiSel),
    .orMode(orMode), .shiftAmt(shiftAmt), .dataIn(dataIn), .expClr(expClr),
    .result(result), .expOut(expOut), .blockExp(blockExp)
  );

  typedef struct {
    logic [31:0] res;
    int          ex;
    int          blk;
    string       tag;
  } item_t;

  item_t sb[$];
  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  logic [31:0] mRes = '0;
  int          mExp = 0;
  int          mBlk = 0;

  function automatic int refExp(logic [15:0] d);
    int k = 0;
    while (k < 15 && d[14-k] == d[15]) k++;
    return -k;
  endfunction

  function automatic logic [31:0] refShift(logic [31:0] v, int amt, bit ar);
    logic [31:0] r = v;
    logic        fill = ar ? v[31] : 1'b0;
    if (amt >= 0) begin
      for (int i = 0; i < amt; i++) r = {r[30:0], 1'b0};
    end else begin
      for (int i = 0; i < -amt; i++) r = {fill, r[31:1]};
    end
    return r;
  endfunction

  task automatic step(input bit vld, input int op, input bit hi, input bit orm,
                      input int amt, input logic [15:0] d, input bit clr, input string tag);
    logic [31:0] pl;
    logic [31:0] v;
    int          e;
    item_t       it;
    @(negedge clk);
    opValid  = vld;
    opCode   = op[2:0];
    hiSel    = hi;
    orMode   = orm;
    shiftAmt = amt[7:0];
    dataIn   = d;
    expClr   = clr;
    @(posedge clk);
    #1;
    pl = hi ? {d, 16'h0} : {16'h0, d};
    e  = refExp(d);
    v  = '0;
    if (vld) begin
      case (op)
        0: v = refShift(pl, amt, 0);
        1: v = refShift(pl, amt, 1);
        2: if (hi) begin mExp = e; v = refShift(pl, -e, 1); end
           else v = refShift(pl, -mExp, 1);
        3: v = refShift(pl, -amt, 1);
        4: mExp = e;
        default: ;
      endcase
      if (op <= 3) mRes = orm ? (mRes | v) : v;
    end
    if (vld && op == 4) mBlk = clr ? e : ((e < mBlk) ? e : mBlk);
    else if (clr) mBlk = 0;
    it.res = mRes; it.ex = mExp; it.blk = mBlk; it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      nCmp++;
      if (result !== it.res || $signed(expOut) != it.ex || $signed(blockExp) != it.blk) begin
        nBad++;
        $display("FAIL %s: result=%h exp %h, expOut=%0d exp %0d, blockExp=%0d exp %0d",
                 it.tag, result, it.res, $signed(expOut), it.ex, $signed(blockExp), it.blk);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run did not finish, actual hung, expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #0;
    nCmp++;
    if (result !== 32'h0 || expOut !== 8'h0 || blockExp !== 8'h0) begin
      nBad++;
      $display("FAIL R1: result=%h expOut=%h blockExp=%h exp all zero", result, expOut, blockExp);
    end

    // R3 placement
    step(1, 0, 1, 0, 0, 16'h1234, 0, "R3 upper placement");
    step(1, 0, 0, 0, 0, 16'hABCD, 0, "R3 lower placement");
    // R4 logical
    step(1, 0, 1, 0, 4, 16'h1234, 0, "R4 left 4");
    step(1, 0, 0, 0, -1, 16'h8001, 0, "R4 right 1 zero fill");
    step(1, 0, 1, 0, 32, 16'hFFFF, 0, "R4 left 32");
    step(1, 0, 1, 0, -40, 16'h8000, 0, "R4 right 40");
    step(1, 0, 1, 0, -31, 16'hFFFF, 0, "R4 right 31");
    // R5 arithmetic
    step(1, 1, 1, 0, -4, 16'h8000, 0, "R5 right 4 sign fill");
    step(1, 1, 1, 0, -32, 16'h8000, 0, "R5 right 32 all sign");
    step(1, 1, 1, 0, -128, 16'h4000, 0, "R5 right 128 positive");
    step(1, 1, 0, 0, -4, 16'h8000, 0, "R5 lower no sign extend");
    // R2 hold
    step(0, 0, 1, 0, 5, 16'hFFFF, 0, "R2 idle hold");
    step(0, 1, 0, 1, -3, 16'h0001, 0, "R2 idle hold again");
    // R6 exponent
    step(1, 4, 1, 0, 0, 16'h0F00, 0, "R6 exp 0x0F00");
    step(1, 4, 0, 0, 0, 16'h0000, 0, "R6 exp zero word");
    step(1, 4, 1, 0, 0, 16'hFFFF, 0, "R6 exp all ones");
    step(1, 4, 1, 0, 0, 16'h4000, 0, "R6 exp 0x4000");
    step(1, 4, 1, 0, 0, 16'hC000, 0, "R6 exp 0xC000");
    // R11 block exponent
    step(1, 4, 1, 0, 0, 16'h0F00, 1, "R11 clear with derive");
    step(1, 4, 1, 0, 0, 16'h2000, 0, "R11 larger exp keeps min");
    step(1, 4, 1, 0, 0, 16'h0080, 0, "R11 smaller exp lowers min");
    step(0, 0, 0, 0, 0, 16'h0000, 1, "R11 clear alone");
    step(1, 4, 1, 0, 0, 16'h7FFF, 0, "R11 derive after clear");
    // R7 normalize upper
    step(1, 2, 1, 0, 9, 16'hFFFF, 0, "R7 normalize all ones");
    step(1, 2, 1, 0, 0, 16'hF123, 0, "R7 normalize negative");
    step(1, 2, 1, 0, 0, 16'h0040, 0, "R7 normalize 0x0040");
    // R8 + R10 normalize lower with OR
    step(1, 2, 0, 1, 0, 16'h1234, 0, "R8 R10 normalize lower OR");
    step(1, 2, 0, 0, -5, 16'h00FF, 0, "R8 normalize lower held exp");
    // R9 denormalize
    step(1, 3, 1, 0, 3, 16'h4000, 0, "R9 denorm right 3");
    step(1, 3, 1, 0, 5, 16'h9000, 0, "R9 denorm right 5 negative");
    step(1, 3, 1, 0, -1, 16'hC000, 0, "R9 denorm left 1");
    step(1, 3, 1, 0, 40, 16'h8000, 0, "R9 denorm right 40");
    // R10 OR build
    step(1, 0, 1, 0, 0, 16'h00F0, 0, "R10 upper word");
    step(1, 0, 0, 1, 0, 16'h000F, 0, "R10 OR lower word");
    step(1, 1, 0, 1, 8, 16'h0101, 0, "R10 OR shifted");
    // R12 unused codes
    step(1, 5, 1, 0, 3, 16'h1111, 0, "R12 code 5");
    step(1, 6, 0, 1, -3, 16'h0000, 0, "R12 code 6");
    step(1, 7, 1, 1, 1, 16'h0001, 0, "R12 code 7");
    step(0, 0, 0, 0, 0, 16'h0000, 0, "R2 final idle");

    @(negedge clk);
    opValid = 1'b0;
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule